// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single compare channel that watches a free-running time counter. Software arms a compare time; when the counter reaches or steps past that time, the channel raises a sticky event flag, optionally asserts an interrupt, and drives an output pin. The pin either toggles on every event or gives a one-clock high pulse, depending on a 4-bit mode field.

The compare register is double buffered while the channel runs. With the channel disabled (mode zero), a compare write arms the value at once. With the channel running, a write is held in a shadow slot and is promoted to the armed slot only at the next event. Software therefore loads the first time while the channel is off, enables it, loads the second time, and from then on writes each new time from the event handler, two events ahead. Compare values and the counter share the same width and wrap together.

Access is a simple write port (enable, one select bit, data) and a read port whose data appears one clock after the select is presented. The time counter may advance by more than one per clock, or stand still.

Top module: `oc_channel`

## Requirements
- R1: After a synchronous reset, flag, irq and pin_out are 0, the mode, interrupt enable and armed compare value are 0, and both read selections return 0.
- R2: An event occurs in a clock where the counter moved from P to C and the armed value A satisfies 0 < (A-P) mod 2^CNT_W <= (C-P) mod 2^CNT_W, the mode being nonzero; a counter that does not move produces no event, and steps larger than one and steps across the wrap point are handled.
- R3: The flag (control word bit 7) becomes 1 in the clock after an event and stays 1 until a control write with bit 7 set clears it; a control write with bit 7 clear leaves it, and an event in the same clock as a clearing write leaves it set.
- R4: irq equals flag AND the interrupt enable (control word bit 6), both registered in the same clock.
- R5: Mode 0x5 (control word bits 5:2) inverts pin_out at every event.
- R6: Mode 0xF makes pin_out 1 for exactly one clock after an event and 0 otherwise.
- R7: Mode 0 produces no events, and a compare write (wr_sel=1) made while mode is 0 becomes the armed value in the next clock.
- R8: A compare write made while mode is nonzero leaves the armed value unchanged and becomes the armed value at the next event, so it governs the event after the next one.
- R9: A compare write keeps only the low CNT_W bits of wr_data.
- R10: A control write of zero disables the channel: mode and interrupt enable become 0, pin_out becomes 0 in the next clock, the flag is kept, and a pending shadow compare value is dropped.
- R11: With rd_sel=0 the read data holds flag at bit 7, interrupt enable at bit 6, mode at bits 5:2 and zero elsewhere; with rd_sel=1 it holds the armed compare value zero-extended; the data appears one clock after rd_sel.
- R12: A nonzero mode other than 0x5 and 0xF sets the flag on an event but leaves pin_out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Current value of the time counter |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 compare value |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 1 | Read target: 0 control word, 1 armed compare value |
| rd_data | output | DATA_W | Registered read data |
| pin_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |
| flag | output | 1 | Event flag |

## Verification
The hardest state to reach is the window test at its edges: an armed value equal to the previous counter value, equal to the new one, or lying across the wrap point, combined with steps of zero, one, several and nearly a full turn. The bench reaches each case by disabling the channel, parking the counter at a chosen start value, arming a compare time with the channel off, enabling pulse mode with the counter held still, and then making one counter step; it sweeps every compare value of an 8-bit counter against several start values and step sizes. Shadow promotion and its loss on disable are reached by writing a compare time while running and reading back the armed value before and after the following event.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef logic [3:0] oc_mode_t;

  localparam oc_mode_t OC_MODE_OFF    = 4'h0;
  localparam oc_mode_t OC_MODE_TOGGLE = 4'h5;
  localparam oc_mode_t OC_MODE_PULSE  = 4'hF;

  // control word layout
  localparam int OC_MODE_LSB = 2;
  localparam int OC_MODE_MSB = 5;
  localparam int OC_IE_BIT   = 6;
  localparam int OC_FLAG_BIT = 7;
  localparam int OC_CTL_W    = OC_FLAG_BIT - OC_MODE_LSB + 1;

  localparam logic OC_SEL_CTRL = 1'b0;
  localparam logic OC_SEL_CMP  = 1'b1;
endpackage

// File: rtl/oc_match.sv
module oc_match #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] armed,
  output logic             hit
);
  logic [CNT_W-1:0] prev_q;
  logic [CNT_W-1:0] d_step;
  logic [CNT_W-1:0] d_cmp;

  // previous counter sample; loaded during reset too so the first
  // step after reset is measured from a real value
  always_ff @(posedge clk) begin
    prev_q <= cnt_val;
  end

  always_comb begin
    d_step = cnt_val - prev_q;
    d_cmp  = armed - prev_q;
    hit    = en && (d_step != '0) && (d_cmp != '0) && (d_cmp <= d_step);
  end

  // R2: a counter that stands still never produces an event
  a_r2_still_no_event: assert property (@(posedge clk) disable iff (rst)
    $stable(cnt_val) |-> !hit);

  // R7: no event while the channel is off
  a_r7_off_no_event: assert property (@(posedge clk) disable iff (rst)
    !en |-> !hit);
endmodule

// File: rtl/oc_cmp_buf.sv
module oc_cmp_buf #(
  parameter int CNT_W  = 31,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              hit,
  input  logic              wr_cmp,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  armed
);
  localparam logic [DATA_W-1:0] CMP_MASK = DATA_W'((64'd1 << CNT_W) - 64'd1);

  logic [CNT_W-1:0] armed_q;
  logic [CNT_W-1:0] shadow_q;
  logic             shadow_vld_q;
  logic [CNT_W-1:0] wr_val;

  assign wr_val = wr_data[CNT_W-1:0];
  assign armed  = armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q      <= '0;
      shadow_q     <= '0;
      shadow_vld_q <= 1'b0;
    end else if (!active) begin
      shadow_vld_q <= 1'b0;
      if (wr_cmp) armed_q <= wr_val;
    end else begin
      if (hit && shadow_vld_q) armed_q <= shadow_q;
      if (wr_cmp) begin
        shadow_q     <= wr_val;
        shadow_vld_q <= 1'b1;
      end else if (hit) begin
        shadow_vld_q <= 1'b0;
      end
    end
  end

  // R9, R7: direct load while off keeps only the counter-wide bits
  a_r9_masked_load: assert property (@(posedge clk) disable iff (rst)
    (wr_cmp && !active) |=> (DATA_W'(armed_q) == ($past(wr_data) & CMP_MASK)));

  // R8: the shadow value is promoted at the event
  a_r8_promote: assert property (@(posedge clk) disable iff (rst)
    (active && hit && shadow_vld_q) |=> (armed_q == $past(shadow_q)));

  // R8: between events a running channel keeps its armed value
  a_r8_hold_armed: assert property (@(posedge clk) disable iff (rst)
    (active && !hit) |=> $stable(armed_q));
endmodule

// File: rtl/oc_ctrl.sv
module oc_ctrl
  import oc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                hit,
  input  logic                wr_ctrl,
  input  logic [OC_CTL_W-1:0] ctl_bits,
  output oc_mode_t            mode_q,
  output logic                ie_q,
  output logic                flag_q,
  output logic                irq_q,
  output logic                pin_q
);
  localparam int M_LO = OC_MODE_LSB - OC_MODE_LSB;
  localparam int M_HI = OC_MODE_MSB - OC_MODE_LSB;
  localparam int IE_I = OC_IE_BIT - OC_MODE_LSB;
  localparam int FL_I = OC_FLAG_BIT - OC_MODE_LSB;

  oc_mode_t mode_d;
  logic     ie_d;
  logic     flag_d;
  logic     pin_d;
  logic     clr_req;

  always_comb begin
    clr_req = wr_ctrl && ctl_bits[FL_I];
    mode_d  = wr_ctrl ? oc_mode_t'(ctl_bits[M_HI:M_LO]) : mode_q;
    ie_d    = wr_ctrl ? ctl_bits[IE_I] : ie_q;
    // an event outranks a clearing write in the same clock
    flag_d  = hit ? 1'b1 : (clr_req ? 1'b0 : flag_q);

    if (mode_d == OC_MODE_OFF) begin
      pin_d = 1'b0;
    end else if (hit) begin
      unique case (mode_q)
        OC_MODE_TOGGLE: pin_d = ~pin_q;
        OC_MODE_PULSE:  pin_d = 1'b1;
        default:        pin_d = pin_q;
      endcase
    end else if (mode_q == OC_MODE_PULSE) begin
      pin_d = 1'b0;
    end else begin
      pin_d = pin_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= OC_MODE_OFF;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
      irq_q  <= flag_d & ie_d;
      pin_q  <= pin_d;
    end
  end

  a_r3_flag_on_event: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q);

  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_req) |=> flag_q);

  a_r4_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq_q == (flag_q && ie_q));

  a_r10_off_pin_low: assert property (@(posedge clk) disable iff (rst)
    (mode_q == OC_MODE_OFF) |-> !pin_q);

  a_r5_toggle_flip: assert property (@(posedge clk) disable iff (rst)
    (mode_q == OC_MODE_TOGGLE && hit && !wr_ctrl) |=> (pin_q != $past(pin_q)));

  a_r6_pulse_short: assert property (@(posedge clk) disable iff (rst)
    (mode_q == OC_MODE_PULSE && pin_q && !hit && !wr_ctrl) |=> !pin_q);
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W  = 31,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              pin_out,
  output logic              irq,
  output logic              flag
);
  oc_mode_t          mode_q;
  logic              ie_q;
  logic              flag_q;
  logic              irq_q;
  logic              pin_q;
  logic              hit;
  logic              active;
  logic              wr_ctrl;
  logic              wr_cmp;
  logic [CNT_W-1:0]  armed;
  logic [DATA_W-1:0] ctl_word;
  logic [DATA_W-1:0] rd_q;

  assign active  = (mode_q != OC_MODE_OFF);
  assign wr_ctrl = wr_en && (wr_sel == OC_SEL_CTRL);
  assign wr_cmp  = wr_en && (wr_sel == OC_SEL_CMP);

  oc_match #(.CNT_W(CNT_W)) u_match (
    .clk     (clk),
    .rst     (rst),
    .en      (active),
    .cnt_val (cnt_val),
    .armed   (armed),
    .hit     (hit)
  );

  oc_cmp_buf #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .active  (active),
    .hit     (hit),
    .wr_cmp  (wr_cmp),
    .wr_data (wr_data),
    .armed   (armed)
  );

  oc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .wr_ctrl  (wr_ctrl),
    .ctl_bits (wr_data[OC_FLAG_BIT:OC_MODE_LSB]),
    .mode_q   (mode_q),
    .ie_q     (ie_q),
    .flag_q   (flag_q),
    .irq_q    (irq_q),
    .pin_q    (pin_q)
  );

  always_comb begin
    ctl_word = '0;
    ctl_word[OC_FLAG_BIT] = flag_q;
    ctl_word[OC_IE_BIT]   = ie_q;
    ctl_word[OC_MODE_MSB:OC_MODE_LSB] = mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= (rd_sel == OC_SEL_CMP) ? DATA_W'(armed) : ctl_word;
  end

  assign rd_data = rd_q;
  assign pin_out = pin_q;
  assign irq     = irq_q;
  assign flag    = flag_q;

  // R11: read data follows the selection one clock later
  a_r11_read_flag: assert property (@(posedge clk) disable iff (rst)
    (!rd_sel && !$past(rst)) |=> (rd_data[OC_FLAG_BIT] == $past(flag_q)));
endmodule

// File: tb/oc_channel_tb.sv
module oc_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int DW = 32;
  localparam int MASK = (1 << W) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  cnt = '0;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_sel = 1'b0;
  logic [DW-1:0] rd_data;
  logic          pin_out;
  logic          irq;
  logic          flag;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  oc_channel #(.CNT_W(W), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .cnt_val(cnt), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .pin_out(pin_out), .irq(irq), .flag(flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog req=all actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive at the falling edge, return at the next falling edge
  task automatic cyc(input bit we, input bit sel, input logic [31:0] d, input logic [W-1:0] c);
    wr_en = we; wr_sel = sel; wr_data = d; cnt = c;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input bit sel, output logic [31:0] v);
    rd_sel = sel;
    cyc(1'b0, 1'b0, 32'h0, cnt);
    v = rd_data;
  endtask

  logic [31:0] v;

  initial begin
    @(negedge clk);
    rst = 1'b1;
    repeat (3) cyc(1'b0, 1'b0, 32'h0, 8'd0);
    chk("R1 flag", {31'b0, flag}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pin", {31'b0, pin_out}, 0);
    rst = 1'b0;
    rd(1'b0, v); chk("R1 ctrl read", v, 0);
    rd(1'b1, v); chk("R1 cmp read", v, 0);

    // toggle mode with double buffering
    cyc(1'b1, 1'b0, 32'h80, 8'd0);
    cyc(1'b1, 1'b1, 32'd10, 8'd0);            // off: arms directly (R7)
    rd(1'b1, v); chk("R7 direct arm", v, 10);
    cyc(1'b1, 1'b0, 32'h14, 8'd0);            // mode 5
    cyc(1'b1, 1'b1, 32'd20, 8'd0);            // running: shadow
    rd(1'b1, v); chk("R8 armed unchanged", v, 10);
    cyc(1'b0, 1'b0, 32'h0, 8'd10);
    chk("R5 toggle first", {31'b0, pin_out}, 1);
    chk("R3 flag set", {31'b0, flag}, 1);
    chk("R4 irq off with ie 0", {31'b0, irq}, 0);
    rd(1'b1, v); chk("R8 promoted", v, 20);
    cyc(1'b1, 1'b0, 32'h14, 8'd10);
    chk("R3 bit7 zero keeps flag", {31'b0, flag}, 1);
    cyc(1'b1, 1'b0, 32'h94, 8'd10);
    chk("R3 w1c clears", {31'b0, flag}, 0);
    cyc(1'b1, 1'b1, 32'd30, 8'd10);
    cyc(1'b0, 1'b0, 32'h0, 8'd15);
    chk("R2 short of compare", {31'b0, flag}, 0);
    chk("R5 pin held", {31'b0, pin_out}, 1);
    cyc(1'b0, 1'b0, 32'h0, 8'd20);
    chk("R5 toggle second", {31'b0, pin_out}, 0);
    cyc(1'b1, 1'b0, 32'h94, 8'd30);           // clear during event
    chk("R3 event beats clear", {31'b0, flag}, 1);
    chk("R5 toggle third", {31'b0, pin_out}, 1);
    rd(1'b1, v); chk("R8 no shadow keeps armed", v, 30);
    rd(1'b0, v); chk("R11 ctrl layout", v, 32'h94);

    // disable drops shadow and lowers pin
    cyc(1'b1, 1'b1, 32'd40, 8'd30);
    cyc(1'b1, 1'b0, 32'h0, 8'd30);
    chk("R10 pin low", {31'b0, pin_out}, 0);
    rd(1'b0, v); chk("R10 ctrl zero keeps flag", v, 32'h80);
    cyc(1'b1, 1'b0, 32'h94, 8'd30);
    cyc(1'b0, 1'b0, 32'h0, 8'd45);
    chk("R10 shadow dropped no event", {31'b0, flag}, 0);
    rd(1'b1, v); chk("R10 armed kept", v, 30);

    // interrupt gating
    cyc(1'b1, 1'b0, 32'h80, 8'd45);
    cyc(1'b1, 1'b1, 32'd60, 8'd45);
    cyc(1'b1, 1'b0, 32'h14, 8'd45);
    cyc(1'b0, 1'b0, 32'h0, 8'd60);
    chk("R4 flag without irq", {30'b0, flag, irq}, 2);
    cyc(1'b1, 1'b0, 32'h54, 8'd60);
    chk("R4 irq after enable", {31'b0, irq}, 1);
    cyc(1'b1, 1'b0, 32'hD4, 8'd60);
    chk("R4 irq falls with flag", {30'b0, flag, irq}, 0);

    // other nonzero mode
    cyc(1'b1, 1'b0, 32'h80, 8'd60);
    cyc(1'b1, 1'b1, 32'd70, 8'd60);
    cyc(1'b1, 1'b0, 32'h0C, 8'd60);
    cyc(1'b0, 1'b0, 32'h0, 8'd70);
    chk("R12 flag set", {31'b0, flag}, 1);
    chk("R12 pin unchanged", {31'b0, pin_out}, 0);

    // mask
    cyc(1'b1, 1'b0, 32'h80, 8'd70);
    cyc(1'b1, 1'b1, 32'hABCDEF05, 8'd70);
    rd(1'b1, v); chk("R9 masked compare", v, 32'h05);

    // window sweep in pulse mode
    begin
      int starts[4] = '{0, 100, 250, 255};
      int steps[5]  = '{0, 1, 3, 9, 255};
      foreach (starts[i]) begin
        foreach (steps[j]) begin
          for (int c = 0; c <= MASK; c++) begin
            int p  = starts[i];
            int s  = steps[j];
            int dc = (c - p) & MASK;
            int nx = (p + s) & MASK;
            logic e;
            e = (s != 0) && (dc != 0) && (dc <= s);
            cyc(1'b1, 1'b0, 32'h80, cnt);
            cyc(1'b1, 1'b1, 32'(c), W'(p));
            cyc(1'b1, 1'b0, 32'h7C, W'(p));
            cyc(1'b0, 1'b0, 32'h0, W'(nx));
            chk("R2 window flag", {31'b0, flag}, {31'b0, e});
            chk("R6 pulse on event", {31'b0, pin_out}, {31'b0, e});
            chk("R4 irq follows", {31'b0, irq}, {31'b0, e});
            cyc(1'b0, 1'b0, 32'h0, W'(nx));
            chk("R6 pulse ends", {31'b0, pin_out}, 0);
            chk("R3 flag held", {31'b0, flag}, {31'b0, e});
          end
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule